// File: doc/BRIEF.md
# UART FIFO Interrupt Event Generator

This block turns the fill levels and traffic strobes of a UART's transmit and receive FIFOs into single-cycle interrupt event pulses. A separate interrupt-state register latches these pulses. The FIFOs and the register bus sit outside the block. The block only watches levels and strobes and decides when something worth reporting has happened.

Five events are produced:

- **Transmit watermark:** the transmit level falls strictly below its threshold.
- **Receive watermark:** the receive level climbs to or past its threshold.
- **Transmit empty:** a dequeue drains the last transmit byte.
- **Receive overflow:** a character arrives while the receive FIFO is full, and that character is lost.
- **Receive timeout:** data has sat unread in the receive FIFO for a programmed number of bit times.

Both watermark events are edge events. A condition that stays true never reports twice. The timeout timer counts bit ticks. It restarts only when the receive depth changes, when a read strobe is seen, or when the timer itself expires.

Top module: `uart_fifo_evt`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all five event outputs are low. Levels are treated as zero, and the watermark history is preset so that no watermark edge is pending.
- R2: `ev_tx_wm` pulses high for one cycle, two clock edges after the edge that samples a `tx_level` strictly below `tx_thresh`, when the previously sampled level was not below it.
- R3: `ev_rx_wm` pulses high for one cycle, two clock edges after the edge that samples an `rx_level` greater than or equal to `rx_thresh`, when the previously sampled level was below it.
- R4: A watermark condition that stays true, or moves to another value that still satisfies it, raises no further event. An empty transmit FIFO that idles out of reset raises no transmit watermark event.
- R5: `ev_tx_empty` pulses for one cycle after the edge that samples `tx_pop` high with `tx_level` equal to 1. A pop at any other level raises nothing.
- R6: `ev_rx_ovf` pulses for one cycle after the edge that samples `rx_push_req` and `rx_full` both high. Either one alone raises nothing.
- R7: With `to_en` high and `rx_level` non-zero, the timeout counter advances on each edge that samples `bit_tick` high. `ev_rx_timeout` pulses one cycle after the tick that brings the count to `to_limit`. The counter then restarts, so a steady non-empty FIFO reports every `to_limit` ticks.
- R8: A change of `rx_level`, or an `rx_read` strobe, restarts the counter at zero. A tick on that same edge is not counted.
- R9: A push while the receive FIFO is full, with the level unchanged, does not restart the timeout counter.
- R10: The counter is held at zero while `rx_level` is zero or `to_en` is low. A `to_limit` of zero never raises a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | LVL_W | Transmit FIFO fill level, 0 to DEPTH |
| rx_level | input | LVL_W | Receive FIFO fill level, 0 to DEPTH |
| tx_thresh | input | LVL_W | Transmit watermark threshold |
| rx_thresh | input | LVL_W | Receive watermark threshold |
| tx_pop | input | 1 | Transmitter dequeues one byte this cycle |
| rx_push_req | input | 1 | Receiver offers one character this cycle |
| rx_full | input | 1 | Receive FIFO is full |
| rx_read | input | 1 | Software reads one receive byte this cycle |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| to_limit | input | TO_W | Timeout length in bit times |
| to_en | input | 1 | Timeout enable |
| ev_tx_wm | output | 1 | Transmit watermark event |
| ev_rx_wm | output | 1 | Receive watermark event |
| ev_tx_empty | output | 1 | Transmit empty event |
| ev_rx_ovf | output | 1 | Receive overflow event |
| ev_rx_timeout | output | 1 | Receive timeout event |

## Verification
The bench builds the block with DEPTH 32 and TO_W 4. With these values the full-scale level of 32 can be driven into the receive watermark comparator. A timeout limit of 5 lets periodic expiry, restarts by depth change and by read, and the no-restart case of a dropped character all fit into a few dozen cycles. A scoreboard pairs each expected pulse with the exact cycle it must appear in. Any pulse with no matching entry counts as a failure, which is how the no-repeat and ignored-stimulus requirements are checked.

// File: rtl/fifo_evt_pkg.sv
// Package: shared types for the FIFO event generator.
// Assumes: nothing beyond IEEE 1800-2017.
package fifo_evt_pkg;

    // Which crossing a watermark detector reports.
    typedef enum logic {
        WM_FALL_BELOW = 1'b0,   // level < threshold
        WM_RISE_TO    = 1'b1    // level >= threshold
    } wm_kind_e;

endpackage

// File: rtl/fifo_evt_wm.sv
// Module: watermark edge detector.
// Registers a FIFO level, compares it combinationally with a threshold,
// and pulses for one cycle when the comparison turns from false to true.
// Assumes: level and threshold are in the same clock domain.
module fifo_evt_wm
    import fifo_evt_pkg::*;
#(
    parameter int       LVL_W = 6,
    parameter wm_kind_e KIND  = WM_FALL_BELOW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             ev
);

    logic [LVL_W-1:0] lvl_q;
    logic             cond;
    logic             cond_prev;

    // Pick the comparison sense from the variant parameter.
    generate
        if (KIND == WM_FALL_BELOW) begin : g_below
            always_comb cond = (lvl_q < thresh);
        end else begin : g_rise
            always_comb cond = (lvl_q >= thresh);
        end
    endgenerate

    // Sample the level, keep the comparison history, register the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q     <= '0;
            cond_prev <= 1'b1;
            ev        <= 1'b0;
        end else begin
            lvl_q     <= level;
            cond_prev <= cond;
            ev        <= cond && !cond_prev;
        end
    end

    AST_WM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> !ev);                                          // R4

endmodule

// File: rtl/fifo_evt_strobe.sv
// Module: strobe-based events (transmit empty, receive overflow).
// Assumes: tx_level is the level before the pop of this cycle.
module fifo_evt_strobe #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tx_pop,
    input  logic             rx_push_req,
    input  logic             rx_full,
    output logic             ev_tx_empty,
    output logic             ev_rx_ovf
);

    localparam logic [LVL_W-1:0] LAST_ONE = LVL_W'(1);

    // Register a pulse when the last byte leaves or a push hits a full FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_tx_empty <= 1'b0;
            ev_rx_ovf   <= 1'b0;
        end else begin
            ev_tx_empty <= tx_pop && (tx_level == LAST_ONE);
            ev_rx_ovf   <= rx_push_req && rx_full;
        end
    end

    AST_TXE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_empty |-> $past(tx_pop && (tx_level == LAST_ONE))); // R5
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ovf |-> $past(rx_push_req && rx_full));          // R6

endmodule

// File: rtl/fifo_evt_timeout.sv
// Module: receive timeout timer.
// Counts bit ticks while enabled and the receive FIFO holds data; fires at
// the programmed limit; restarts on a depth change, a read, or expiry.
// Assumes: bit_tick is a single-cycle strobe; a zero limit disables firing.
module fifo_evt_timeout #(
    parameter int LVL_W = 6,
    parameter int TO_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_read,
    input  logic             bit_tick,
    input  logic [TO_W-1:0]  to_limit,
    input  logic             to_en,
    output logic             ev
);

    logic [TO_W-1:0]  cnt;
    logic [TO_W:0]    cnt_inc;
    logic [LVL_W-1:0] lvl_q;
    logic             active;
    logic             restart;
    logic             hit;

    // Decode activity, restart causes and the expiry condition.
    always_comb begin
        active  = to_en && (rx_level != '0);
        restart = (rx_level != lvl_q) || rx_read;
        cnt_inc = {1'b0, cnt} + 1'b1;
        hit     = active && bit_tick && !restart && (to_limit != '0)
                  && (cnt_inc == {1'b0, to_limit});
    end

    // Track the level, advance or clear the counter, register expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            cnt   <= '0;
            ev    <= 1'b0;
        end else begin
            lvl_q <= rx_level;
            ev    <= hit;
            if (!active || restart || hit) begin
                cnt <= '0;
            end else if (bit_tick) begin
                cnt <= cnt_inc[TO_W-1:0];
            end
        end
    end

    AST_TO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_en || (rx_level == '0)) |=> (cnt == '0));        // R10
    AST_TO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev |-> $past(to_en && bit_tick && (rx_level != '0))); // R7
    AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && active) |=> (cnt == '0));                 // R8

endmodule

// File: rtl/uart_fifo_evt.sv
// Module: top of the UART FIFO interrupt event generator.
// Produces one-cycle event pulses for an external interrupt-state register.
// Assumes: all inputs synchronous to clk; levels range 0 to DEPTH.
module uart_fifo_evt
    import fifo_evt_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int TO_W  = 24,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic             tx_pop,
    input  logic             rx_push_req,
    input  logic             rx_full,
    input  logic             rx_read,
    input  logic             bit_tick,
    input  logic [TO_W-1:0]  to_limit,
    input  logic             to_en,
    output logic             ev_tx_wm,
    output logic             ev_rx_wm,
    output logic             ev_tx_empty,
    output logic             ev_rx_ovf,
    output logic             ev_rx_timeout
);

    fifo_evt_wm #(.LVL_W(LVL_W), .KIND(WM_FALL_BELOW)) u_tx_wm (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (tx_level),
        .thresh (tx_thresh),
        .ev     (ev_tx_wm)
    );

    fifo_evt_wm #(.LVL_W(LVL_W), .KIND(WM_RISE_TO)) u_rx_wm (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (rx_level),
        .thresh (rx_thresh),
        .ev     (ev_rx_wm)
    );

    fifo_evt_strobe #(.LVL_W(LVL_W)) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_level    (tx_level),
        .tx_pop      (tx_pop),
        .rx_push_req (rx_push_req),
        .rx_full     (rx_full),
        .ev_tx_empty (ev_tx_empty),
        .ev_rx_ovf   (ev_rx_ovf)
    );

    fifo_evt_timeout #(.LVL_W(LVL_W), .TO_W(TO_W)) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_level),
        .rx_read  (rx_read),
        .bit_tick (bit_tick),
        .to_limit (to_limit),
        .to_en    (to_en),
        .ev       (ev_rx_timeout)
    );

    AST_TXWM_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_wm |-> $past(tx_level < tx_thresh, 2));           // R2
    AST_RXWM_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_wm |-> $past(rx_level >= rx_thresh, 2));          // R3
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> !(ev_tx_wm || ev_rx_wm || ev_tx_empty
                            || ev_rx_ovf || ev_rx_timeout));    // R1

endmodule

// File: tb/uart_fifo_evt_bench.sv
// Scoreboard bench: the driver queues expected (event, cycle) pairs and the
// monitor matches every observed pulse against them at the falling edge.
module uart_fifo_evt_bench;

    localparam int DEPTH = 32;
    localparam int TO_W  = 4;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
    logic [LVL_W-1:0] tx_thresh = LVL_W'(4), rx_thresh = LVL_W'(3);
    logic             tx_pop = 1'b0, rx_push_req = 1'b0, rx_full = 1'b0;
    logic             rx_read = 1'b0, bit_tick = 1'b1, to_en = 1'b0;
    logic [TO_W-1:0]  to_limit = TO_W'(5);
    logic             ev_tx_wm, ev_rx_wm, ev_tx_empty, ev_rx_ovf, ev_rx_timeout;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit run    = 1'b0;
    bit done   = 1'b0;

    typedef struct { int at; int kind; } exp_t;
    exp_t sb[$];

    uart_fifo_evt #(.DEPTH(DEPTH), .TO_W(TO_W)) u_uart_fifo_evt (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tx_pop(tx_pop), .rx_push_req(rx_push_req), .rx_full(rx_full),
        .rx_read(rx_read), .bit_tick(bit_tick),
        .to_limit(to_limit), .to_en(to_en),
        .ev_tx_wm(ev_tx_wm), .ev_rx_wm(ev_rx_wm), .ev_tx_empty(ev_tx_empty),
        .ev_rx_ovf(ev_rx_ovf), .ev_rx_timeout(ev_rx_timeout)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic string req_of(int kind);
        case (kind)
            0: return "R2 tx_wm";
            1: return "R3 rx_wm";
            2: return "R5 tx_empty";
            3: return "R6 rx_ovf";
            default: return "R7 rx_timeout";
        endcase
    endfunction

    task automatic expect_ev(int kind, int at);
        sb.push_back('{at, kind});
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Monitor: match each pulse, flag unexpected pulses and missed entries.
    always @(negedge clk) begin
        if (run) begin
            logic [4:0] seen;
            seen = {ev_rx_timeout, ev_rx_ovf, ev_tx_empty, ev_rx_wm, ev_tx_wm};
            for (int k = 0; k < 5; k++) begin
                if (seen[k]) begin
                    int idx;
                    idx = -1;
                    for (int i = 0; i < sb.size(); i++)
                        if (idx < 0 && sb[i].kind == k && sb[i].at == cyc) idx = i;
                    checks++;
                    if (idx >= 0) sb.delete(idx);
                    else begin
                        fails++;
                        $display("FAIL %s (R4/R9/R10 no-event rule): unexpected pulse at cycle %0d, actual 1 expected 0",
                                 req_of(k), cyc);
                    end
                end
            end
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].at < cyc) begin
                    checks++;
                    fails++;
                    $display("FAIL %s: missing pulse due at cycle %0d, actual 0 expected 1",
                             req_of(sb[i].kind), sb[i].at);
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs low under reset
        wait_cyc(3);
        checks++;
        if ({ev_tx_wm, ev_rx_wm, ev_tx_empty, ev_rx_ovf, ev_rx_timeout} != 5'b0) begin
            fails++;
            $display("FAIL R1: events under reset actual %b expected 00000",
                     {ev_tx_wm, ev_rx_wm, ev_tx_empty, ev_rx_ovf, ev_rx_timeout});
        end
        rst_n = 1'b1;
        run   = 1'b1;
        wait_cyc(6);                    // R1/R4: empty TX idles, no event

        // R2/R4: transmit watermark falling below 4
        tx_level = 6'd5;  wait_cyc(4);
        tx_level = 6'd3;  expect_ev(0, cyc + 2); wait_cyc(6);
        tx_level = 6'd2;  wait_cyc(4);  // R4: still true, no repeat
        tx_level = 6'd4;  wait_cyc(4);
        tx_level = 6'd1;  expect_ev(0, cyc + 2); wait_cyc(4);

        // R3/R4: receive watermark reaching 3
        rx_level = 6'd2;  wait_cyc(4);
        rx_level = 6'd3;  expect_ev(1, cyc + 2); wait_cyc(6);
        rx_level = 6'd32; wait_cyc(4);  // R4: full scale, still true
        rx_level = 6'd1;  wait_cyc(4);
        rx_level = 6'd4;  expect_ev(1, cyc + 2); wait_cyc(4);
        rx_level = 6'd0;  wait_cyc(4);

        // R5: pop of last byte vs pop with bytes left
        tx_pop = 1'b1; expect_ev(2, cyc + 1); wait_cyc(1);
        tx_pop = 1'b0; wait_cyc(3);
        tx_level = 6'd3; wait_cyc(4);
        tx_pop = 1'b1; wait_cyc(1);
        tx_pop = 1'b0; wait_cyc(3);

        // R6: overflow only with push and full together
        rx_push_req = 1'b1; rx_full = 1'b1; expect_ev(3, cyc + 1); wait_cyc(1);
        rx_full = 1'b0; wait_cyc(1);
        rx_push_req = 1'b0; rx_full = 1'b1; wait_cyc(2);
        rx_full = 1'b0; wait_cyc(3);

        // R10: enabled but empty, counter held
        rx_thresh = 6'd20; to_en = 1'b1; to_limit = 4'd5; wait_cyc(10);

        // R7: periodic expiry with a steady non-empty FIFO
        rx_level = 6'd1;
        expect_ev(4, cyc + 6); expect_ev(4, cyc + 11);
        wait_cyc(12);
        // R8: depth change restarts; R9: dropped push does not
        rx_level = 6'd2; expect_ev(4, cyc + 6);
        wait_cyc(3);
        rx_push_req = 1'b1; rx_full = 1'b1; expect_ev(3, cyc + 1); wait_cyc(1);
        rx_push_req = 1'b0; rx_full = 1'b0; wait_cyc(5);
        // R8: read strobe restarts
        rx_read = 1'b1; expect_ev(4, cyc + 6); wait_cyc(1);
        rx_read = 1'b0; wait_cyc(7);
        // R10: emptied FIFO holds the counter
        rx_level = 6'd0; wait_cyc(10);
        // R10: disabled timer with data present
        to_en = 1'b0; rx_level = 6'd3; wait_cyc(20);
        // R7: no ticks, no progress; then ticks resume
        to_en = 1'b1; bit_tick = 1'b0; wait_cyc(20);
        bit_tick = 1'b1; expect_ev(4, cyc + 5); wait_cyc(7);
        // R10: zero limit never fires
        to_limit = 4'd0; wait_cyc(30);

        wait_cyc(5);
        run = 1'b0;
        foreach (sb[i]) begin
            checks++;
            fails++;
            $display("FAIL %s: pulse never seen, due cycle %0d, actual 0 expected 1",
                     req_of(sb[i].kind), sb[i].at);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule